// File: doc/BRIEF.md
# SPI Master Register Front End

This block sits between a processor-style register bus and a separate SPI shift engine. It holds the control word that configures the engine, a two-bit interrupt mask, a status view and a data port. Writes and reads use separate ports. A write takes effect on the clock edge when its strobe is high. Read data is a combinational function of the read address. A read strobe tells the block that software has consumed the value, because reading the data port empties the receive slot.

The block holds one transmit word and one received word. A word written to the data port goes into the transmit slot and is offered to the engine with a valid/ready handshake. The engine delivers received words with a single-cycle valid pulse; the block does not stall it. If a word arrives while the receive slot is still occupied, the old word is kept, the new one is dropped and a sticky lost-data flag is set. A level interrupt is raised whenever an enabled flag is active.

Top module: `spi_reg_front`

## Requirements
- R1: After reset the control and mask registers read 0, status (address 2) reads 0x00000002 (only the transmit-empty flag is set), tx_valid is 0 and irq is 0.
- R2: Address 0 holds the control word. Writable bits are enable (bit 0), master (bit 1), transmit enable (bit 2), receive enable (bit 3), clock polarity (bit 4), clock phase (bit 5), LSB first (bit 6), 16-bit words (bit 10) and divider select (bits 22:20). They read back as written, all other bits read 0, and each drives its cfg_* output.
- R3: Address 1 holds the interrupt mask in bits 1:0 (bit 0 receive-full, bit 1 transmit-empty). All other bits read 0.
- R4: Status at address 2 shows receive-full in bit 0, transmit-empty in bit 1, the engine's eng_busy input in bit 3 and lost-data in bit 4. All other bits read 0.
- R5: A write to address 3 while the transmit slot is empty loads wr_data[15:0] into tx_word, clears transmit-empty and raises tx_valid on the next cycle. A write to address 3 while the slot is full is ignored.
- R6: A cycle with tx_valid and tx_ready both high hands the word over, and transmit-empty is set on the next cycle.
- R7: An rx_valid pulse with receive enable set and the receive slot empty stores rx_word and sets receive-full.
- R8: Reading address 3 returns the stored word in the same cycle. Only a read strobe on address 3 clears receive-full. A read of any other address, or of address 3 without the strobe, leaves it set.
- R9: An rx_valid pulse with receive enable set, while the slot is full and not being read in that cycle, sets lost-data and keeps the old word. If the data read and the new word fall in the same cycle, the new word is stored and no loss is flagged.
- R10: While receive enable is 0, rx_valid changes neither the receive slot nor the lost-data flag.
- R11: Lost-data stays set until a write to address 2 with bit 4 = 1. A status write with bit 4 = 0 has no effect.
- R12: In 8-bit mode (control bit 10 = 0), data reads return bits 31:8 as zero. In 16-bit mode they return the 16-bit word in bits 15:0.
- R13: irq is high exactly when (mask bit 0 and receive-full) or (mask bit 1 and transmit-empty).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_addr | input | 2 | Register select for writes |
| wr_data | input | 32 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_addr | input | 2 | Register select for reads |
| rd_en | input | 1 | Read strobe (marks a consuming read) |
| rd_data | output | 32 | Combinational read data |
| cfg_enable | output | 1 | Engine enable |
| cfg_master | output | 1 | Master mode select |
| cfg_tx_on | output | 1 | Transmit enable |
| cfg_rx_on | output | 1 | Receive enable |
| cfg_cpol | output | 1 | Idle clock level |
| cfg_cpha | output | 1 | Clock phase |
| cfg_lsb_first | output | 1 | Bit order, LSB first when 1 |
| cfg_wide | output | 1 | 16-bit words when 1, 8-bit when 0 |
| cfg_div_sel | output | 3 | Serial clock divider select |
| tx_valid | output | 1 | Transmit word available to the engine |
| tx_ready | input | 1 | Engine takes the transmit word |
| tx_word | output | 16 | Transmit word |
| rx_valid | input | 1 | Engine delivers a received word |
| rx_word | input | 16 | Received word |
| eng_busy | input | 1 | Engine activity, mirrored into status |
| irq | output | 1 | Level interrupt |

## Verification
A wrong flag shows up in the status read one cycle after the event that caused it, because the status read path is combinational from the flag registers. An error in the receive or transmit slot appears at the same time on rd_data or tx_word. A flag held in the wrong state also moves irq in that cycle whenever the matching mask bit is set. A missed clear or a missed set of lost-data stays visible on every later status read, because the flag is sticky. The bench therefore reads status after each single event, and it tests the same-cycle collision of a data read with an arriving word separately.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;

  localparam int unsigned ADDR_W = 2;
  localparam int unsigned DIV_W  = 3;
  localparam int unsigned FLAG_N = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 2'd0,
    REG_MASK = 2'd1,
    REG_STAT = 2'd2,
    REG_DATA = 2'd3
  } reg_sel_e;

  // control word bit positions (software-visible layout)
  localparam int unsigned CB_EN     = 0;
  localparam int unsigned CB_MASTER = 1;
  localparam int unsigned CB_TXON   = 2;
  localparam int unsigned CB_RXON   = 3;
  localparam int unsigned CB_CPOL   = 4;
  localparam int unsigned CB_CPHA   = 5;
  localparam int unsigned CB_LSB    = 6;
  localparam int unsigned CB_WIDE   = 10;
  localparam int unsigned CB_DIV    = 20;

  // status bit positions; mask bits share positions 0 and 1
  localparam int unsigned SB_RXF  = 0;
  localparam int unsigned SB_TXE  = 1;
  localparam int unsigned SB_BUSY = 3;
  localparam int unsigned SB_LOST = 4;

  typedef struct packed {
    logic [DIV_W-1:0] div_sel;
    logic             wide;
    logic             lsb_first;
    logic             cpha;
    logic             cpol;
    logic             rx_on;
    logic             tx_on;
    logic             master;
    logic             enable;
  } spi_cfg_t;

endpackage

// File: rtl/spi_rst_sync.sv
module spi_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_core_n = sync_q[STAGES-1];

endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
  import spi_regs_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_mask,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] ctrl_word,
  output logic [FLAG_N-1:0] mask_bits,
  output spi_cfg_t          cfg
);

  localparam logic [DATA_W-1:0] CTRL_KEEP =
      DATA_W'((1 << (CB_LSB + 1)) - 1)
    | DATA_W'(1 << CB_WIDE)
    | DATA_W'(((1 << DIV_W) - 1) << CB_DIV);

  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic [FLAG_N-1:0] mask_q, mask_d;
  logic              ctrl_ce, mask_ce;

  assign ctrl_ce = wr_ctrl;
  assign mask_ce = wr_mask;

  always_comb begin
    ctrl_d = ctrl_q;
    mask_d = mask_q;
    if (ctrl_ce) ctrl_d = wr_data & CTRL_KEEP;
    if (mask_ce) mask_d = wr_data[FLAG_N-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= '0;
    end else begin
      if (ctrl_ce) ctrl_q <= ctrl_d;
      if (mask_ce) mask_q <= mask_d;
    end
  end

  always_comb begin
    cfg.enable    = ctrl_q[CB_EN];
    cfg.master    = ctrl_q[CB_MASTER];
    cfg.tx_on     = ctrl_q[CB_TXON];
    cfg.rx_on     = ctrl_q[CB_RXON];
    cfg.cpol      = ctrl_q[CB_CPOL];
    cfg.cpha      = ctrl_q[CB_CPHA];
    cfg.lsb_first = ctrl_q[CB_LSB];
    cfg.wide      = ctrl_q[CB_WIDE];
    cfg.div_sel   = ctrl_q[CB_DIV +: DIV_W];
  end

  assign ctrl_word = ctrl_q;
  assign mask_bits = mask_q;

endmodule

// File: rtl/spi_tx_slot.sv
module spi_tx_slot #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              take,
  output logic              empty,
  output logic [WORD_W-1:0] word
);

  logic              empty_q, empty_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              accept;
  logic              word_ce;

  // a load is only honoured while the slot is free
  assign accept  = load & empty_q;
  assign word_ce = accept;

  always_comb begin
    empty_d = empty_q;
    word_d  = word_q;
    if (accept) begin
      empty_d = 1'b0;
      word_d  = load_word;
    end else if (take && !empty_q) begin
      empty_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b1;
      word_q  <= '0;
    end else begin
      empty_q <= empty_d;
      if (word_ce) word_q <= word_d;
    end
  end

  assign empty = empty_q;
  assign word  = word_q;

endmodule

// File: rtl/spi_rx_slot.sv
module spi_rx_slot #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arrive,
  input  logic              rx_on,
  input  logic [WORD_W-1:0] arrive_word,
  input  logic              drain,
  input  logic              lost_clr,
  output logic              full,
  output logic [WORD_W-1:0] word,
  output logic              lost
);

  logic              full_q, full_d;
  logic              lost_q, lost_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              take, busy_slot, store, word_ce;

  assign take      = arrive & rx_on;
  // a read in the same cycle frees the slot for the arriving word
  assign busy_slot = full_q & ~drain;
  assign store     = take & ~busy_slot;
  assign word_ce   = store;

  always_comb begin
    full_d = full_q;
    lost_d = lost_q;
    word_d = word_q;
    if (store) begin
      full_d = 1'b1;
      word_d = arrive_word;
    end else if (drain) begin
      full_d = 1'b0;
    end
    if (take && busy_slot) begin
      lost_d = 1'b1;
    end else if (lost_clr) begin
      lost_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      lost_q <= 1'b0;
      word_q <= '0;
    end else begin
      full_q <= full_d;
      lost_q <= lost_d;
      if (word_ce) word_q <= word_d;
    end
  end

  assign full = full_q;
  assign word = word_q;
  assign lost = lost_q;

endmodule

// File: rtl/spi_reg_front.sv
module spi_reg_front
  import spi_regs_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned WORD_W   = 16,
  parameter int unsigned NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en,
  input  logic [1:0]        rd_addr,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              cfg_enable,
  output logic              cfg_master,
  output logic              cfg_tx_on,
  output logic              cfg_rx_on,
  output logic              cfg_cpol,
  output logic              cfg_cpha,
  output logic              cfg_lsb_first,
  output logic              cfg_wide,
  output logic [2:0]        cfg_div_sel,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [WORD_W-1:0] tx_word,
  input  logic              rx_valid,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              eng_busy,
  output logic              irq
);

  logic              rst_core_n;
  logic [DATA_W-1:0] ctrl_word;
  logic [FLAG_N-1:0] irq_mask;
  spi_cfg_t          cfg;
  logic              tx_empty;
  logic              rx_full;
  logic [WORD_W-1:0] rx_buf;
  logic              lost_flag;
  logic              wr_ctrl, wr_mask, wr_stat, wr_dat, rd_drain;
  logic [DATA_W-1:0] stat_word;
  logic [WORD_W-1:0] rx_view;
  logic [FLAG_N-1:0] flag_vec;
  logic [FLAG_N-1:0] irq_terms;

  spi_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  assign wr_ctrl  = wr_en && (wr_addr == REG_CTRL);
  assign wr_mask  = wr_en && (wr_addr == REG_MASK);
  assign wr_stat  = wr_en && (wr_addr == REG_STAT);
  assign wr_dat   = wr_en && (wr_addr == REG_DATA);
  assign rd_drain = rd_en && (rd_addr == REG_DATA);

  spi_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wr_ctrl   (wr_ctrl),
    .wr_mask   (wr_mask),
    .wr_data   (wr_data),
    .ctrl_word (ctrl_word),
    .mask_bits (irq_mask),
    .cfg       (cfg)
  );

  spi_tx_slot #(.WORD_W(WORD_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .load      (wr_dat),
    .load_word (wr_data[WORD_W-1:0]),
    .take      (tx_ready),
    .empty     (tx_empty),
    .word      (tx_word)
  );

  spi_rx_slot #(.WORD_W(WORD_W)) u_rx (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .arrive      (rx_valid),
    .rx_on       (cfg.rx_on),
    .arrive_word (rx_word),
    .drain       (rd_drain),
    .lost_clr    (wr_stat && wr_data[SB_LOST]),
    .full        (rx_full),
    .word        (rx_buf),
    .lost        (lost_flag)
  );

  assign tx_valid      = ~tx_empty;
  assign cfg_enable    = cfg.enable;
  assign cfg_master    = cfg.master;
  assign cfg_tx_on     = cfg.tx_on;
  assign cfg_rx_on     = cfg.rx_on;
  assign cfg_cpol      = cfg.cpol;
  assign cfg_cpha      = cfg.cpha;
  assign cfg_lsb_first = cfg.lsb_first;
  assign cfg_wide      = cfg.wide;
  assign cfg_div_sel   = cfg.div_sel;

  always_comb begin
    stat_word          = '0;
    stat_word[SB_RXF]  = rx_full;
    stat_word[SB_TXE]  = tx_empty;
    stat_word[SB_BUSY] = eng_busy;
    stat_word[SB_LOST] = lost_flag;
  end

  generate
    if (WORD_W > NARROW_W) begin : g_narrow_view
      always_comb begin
        rx_view = rx_buf;
        if (!cfg.wide) rx_view[WORD_W-1:NARROW_W] = '0;
      end
    end else begin : g_full_view
      assign rx_view = rx_buf;
    end
  endgenerate

  always_comb begin
    unique case (reg_sel_e'(rd_addr))
      REG_CTRL: rd_data = ctrl_word;
      REG_MASK: rd_data = DATA_W'(irq_mask);
      REG_STAT: rd_data = stat_word;
      REG_DATA: rd_data = DATA_W'(rx_view);
      default:  rd_data = '0;
    endcase
  end

  assign flag_vec[SB_RXF] = rx_full;
  assign flag_vec[SB_TXE] = tx_empty;

  generate
    for (genvar gi = 0; gi < FLAG_N; gi++) begin : g_irq
      assign irq_terms[gi] = flag_vec[gi] & irq_mask[gi];
    end
  endgenerate

  assign irq = |irq_terms;

endmodule

// File: rtl/spi_reg_front_chk.sv
module spi_reg_front_chk #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned WORD_W   = 16,
  parameter int unsigned NARROW_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_en,
  input logic [1:0]        rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [WORD_W-1:0] tx_word,
  input logic              rx_valid,
  input logic              cfg_rx_on,
  input logic              cfg_wide,
  input logic              irq,
  input logic              tx_empty,
  input logic              rx_full,
  input logic [WORD_W-1:0] rx_buf,
  input logic              lost_flag,
  input logic [1:0]        irq_mask
);

  assert_tx_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd3 && tx_empty) |=>
      (!tx_empty && tx_word == $past(wr_data[WORD_W-1:0])));

  assert_tx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_empty |=> $stable(tx_word));

  assert_tx_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> tx_empty);

  assert_rx_lost_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && cfg_rx_on && rx_full && !(rd_en && rd_addr == 2'd3)) |=>
      (lost_flag && $stable(rx_buf)));

  assert_rx_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !cfg_rx_on && !(rd_en && rd_addr == 2'd3)) |=>
      ($stable(rx_full) && $stable(rx_buf)));

  assert_lost_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_flag && !(wr_en && wr_addr == 2'd2 && wr_data[4])) |=> lost_flag);

  assert_narrow_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 2'd3 && !cfg_wide) |-> (rd_data[DATA_W-1:NARROW_W] == '0));

  assert_irq_source_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (irq_mask != 2'b00));

endmodule

bind spi_reg_front spi_reg_front_chk u_chk (.*);

// File: tb/spi_reg_front_bench.sv
`timescale 1ns/1ps
module spi_reg_front_bench;

  logic        clk;
  logic        rst_n;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic        wr_en;
  logic [1:0]  rd_addr;
  logic        rd_en;
  logic [31:0] rd_data;
  logic        cfg_enable, cfg_master, cfg_tx_on, cfg_rx_on;
  logic        cfg_cpol, cfg_cpha, cfg_lsb_first, cfg_wide;
  logic [2:0]  cfg_div_sel;
  logic        tx_valid;
  logic        tx_ready;
  logic [15:0] tx_word;
  logic        rx_valid;
  logic [15:0] rx_word;
  logic        eng_busy;
  logic        irq;

  int checks = 0;
  int misses = 0;

  spi_reg_front u_spi_reg_front (
    .clk(clk), .rst_n(rst_n),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en),
    .rd_addr(rd_addr), .rd_en(rd_en), .rd_data(rd_data),
    .cfg_enable(cfg_enable), .cfg_master(cfg_master), .cfg_tx_on(cfg_tx_on),
    .cfg_rx_on(cfg_rx_on), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_lsb_first(cfg_lsb_first), .cfg_wide(cfg_wide), .cfg_div_sel(cfg_div_sel),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_word(tx_word),
    .rx_valid(rx_valid), .rx_word(rx_word), .eng_busy(eng_busy), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {op, addr, data, expected}; op 0 = write, op 1 = strobed read and compare
  localparam int NVEC = 13;
  localparam logic [67:0] VEC [NVEC] = '{
    {2'd1, 2'd0, 32'h0,          32'h0},          // R1 ctrl reset
    {2'd1, 2'd1, 32'h0,          32'h0},          // R1 mask reset
    {2'd1, 2'd2, 32'h0,          32'h2},          // R1 status reset
    {2'd0, 2'd0, 32'hFFFF_FFFF,  32'h0},
    {2'd1, 2'd0, 32'h0,          32'h0070_047F},  // R2 writable bits only
    {2'd0, 2'd1, 32'hFFFF_FFFF,  32'h0},
    {2'd1, 2'd1, 32'h0,          32'h3},          // R3 two mask bits
    {2'd0, 2'd1, 32'h0,          32'h0},
    {2'd0, 2'd0, 32'h0050_0432,  32'h0},
    {2'd1, 2'd0, 32'h0,          32'h0050_0432},  // R2 read back
    {2'd0, 2'd2, 32'hFFFF_FFFF,  32'h0},
    {2'd1, 2'd2, 32'h0,          32'h2},          // R4 status not writable
    {2'd1, 2'd3, 32'h0,          32'h0}           // R12 empty data read
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input bit strobe, input logic [31:0] exp,
                    input string req);
    rd_addr = a;
    #1;
    chk(req, rd_data, exp);
    rd_en = strobe;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic push(input logic [15:0] w);
    rx_word = w; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  function automatic logic [31:0] cfg_pack();
    return {20'h0, cfg_div_sel, cfg_wide, cfg_lsb_first, cfg_cpha, cfg_cpol,
            cfg_rx_on, cfg_tx_on, cfg_master, cfg_enable};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, misses);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_addr = '0; wr_data = '0; wr_en = 1'b0;
    rd_addr = '0; rd_en = 1'b0; tx_ready = 1'b0; rx_valid = 1'b0;
    rx_word = '0; eng_busy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 tx_valid", {31'h0, tx_valid}, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][67:66] == 2'd0) wr(VEC[i][65:64], VEC[i][63:32]);
      else rd(VEC[i][65:64], 1'b1, VEC[i][31:0], "R1/R2/R3/R4 vector");
    end

    // R2: fields drive the engine outputs
    chk("R2 cfg outputs", cfg_pack(), 32'h5B2);
    wr(2'd0, 32'h0000_004D);
    chk("R2 cfg outputs alt", cfg_pack(), 32'h04D);
    chk("R13 irq masked off", {31'h0, irq}, 32'h0);

    // R4: busy mirror
    eng_busy = 1'b1;
    rd(2'd2, 1'b0, 32'h0A, "R4 busy bit");
    eng_busy = 1'b0;

    // R5 / R13: transmit slot
    wr(2'd1, 32'h2);
    chk("R13 irq on tx empty", {31'h0, irq}, 32'h1);
    wr(2'd3, 32'h0012_34A5);
    chk("R5 tx_valid", {31'h0, tx_valid}, 32'h1);
    chk("R5 tx_word", {16'h0, tx_word}, 32'h34A5);
    rd(2'd2, 1'b0, 32'h0, "R5 tx empty cleared");
    chk("R13 irq dropped", {31'h0, irq}, 32'h0);
    wr(2'd3, 32'h0000_BEEF);
    chk("R5 write while full ignored", {16'h0, tx_word}, 32'h34A5);

    // R6: handshake
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    chk("R6 tx_valid after take", {31'h0, tx_valid}, 32'h0);
    rd(2'd2, 1'b0, 32'h2, "R6 tx empty set");
    chk("R13 irq back", {31'h0, irq}, 32'h1);

    // R7 / R8: receive, 16-bit mode
    wr(2'd0, 32'h0000_0408);
    wr(2'd1, 32'h1);
    push(16'hC3A5);
    rd(2'd2, 1'b0, 32'h3, "R7 rx full");
    chk("R13 irq on rx full", {31'h0, irq}, 32'h1);
    rd(2'd3, 1'b0, 32'hC3A5, "R8 peek without strobe");
    rd(2'd2, 1'b1, 32'h3, "R8 peek keeps full");
    rd(2'd3, 1'b1, 32'hC3A5, "R8 strobed read");
    rd(2'd2, 1'b0, 32'h2, "R8 full cleared");
    chk("R13 irq after drain", {31'h0, irq}, 32'h0);

    // R12: 8-bit view
    wr(2'd0, 32'h0000_0008);
    push(16'hC3A5);
    rd(2'd3, 1'b0, 32'hA5, "R12 narrow read");
    rd(2'd3, 1'b1, 32'hA5, "R12 narrow strobed read");

    // R9: overrun keeps the old word
    push(16'h0011);
    push(16'h0022);
    rd(2'd2, 1'b0, 32'h13, "R9 lost set");
    rd(2'd3, 1'b0, 32'h11, "R9 old word kept");

    // R11: sticky until a 1 is written to bit 4
    wr(2'd2, 32'hFFFF_FFEF);
    rd(2'd2, 1'b0, 32'h13, "R11 zero write keeps lost");
    wr(2'd2, 32'h0000_0010);
    rd(2'd2, 1'b0, 32'h03, "R11 lost cleared");

    // R9: read and arrival in the same cycle
    rd_addr = 2'd3; rx_word = 16'h0033; rx_valid = 1'b1;
    #1;
    chk("R9 same-cycle read data", rd_data, 32'h11);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; rx_valid = 1'b0;
    rd(2'd2, 1'b0, 32'h03, "R9 no loss on same-cycle read");
    rd(2'd3, 1'b1, 32'h33, "R9 new word stored");

    // R10: receive disabled
    push(16'h0055);
    wr(2'd0, 32'h0);
    push(16'h0066);
    rd(2'd2, 1'b0, 32'h03, "R10 no loss while off");
    rd(2'd3, 1'b1, 32'h55, "R10 word unchanged");
    push(16'h0077);
    rd(2'd2, 1'b0, 32'h02, "R10 nothing stored while off");

    // R1: reset in mid-run
    wr(2'd1, 32'h3);
    wr(2'd3, 32'h0000_1111);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(2'd0, 1'b0, 32'h0, "R1 ctrl after reset");
    rd(2'd1, 1'b0, 32'h0, "R1 mask after reset");
    rd(2'd2, 1'b0, 32'h2, "R1 status after reset");
    chk("R1 tx_valid after reset", {31'h0, tx_valid}, 32'h0);
    chk("R1 irq after reset", {31'h0, irq}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, misses);
    $finish;
  end

endmodule